// File: doc/BRIEF.md
# Clock Quality and Lock Supervisor

This block keeps watch over two clocks that feed a chip's clock tree: the reference oscillator and the PLL output. It also tracks the PLL lock flag and decides which clock source the system runs on. Both monitored clocks enter as plain signals. Each is synchronized into a trusted supervision clock, and its rising edges are counted over a fixed window of trusted cycles. A clock whose count lands outside its programmable limits in two windows back to back is declared failed. Loss of lock is watched continuously while the PLL is running.

Each of the three faults (oscillator failure, PLL output failure, loss of lock) sets its own sticky flag. Software picks, per fault, whether the fault raises the interrupt request or a one-cycle system reset request. A PLL output failure set to the interrupt response also moves the system clock back to the oscillator. The clock stays there until software clears the PLL fault flag. The glitch-free multiplexer itself is outside the block, which only drives its select line.

The mode controller is a five-state machine:
- `ST_BYP_OFF`: bypass, PLL powered down.
- `ST_BYP_RUN`: bypass, PLL running. This is the reset state.
- `ST_WAIT_LOCK`: normal mode has been requested but lock is absent.
- `ST_NORMAL`: the system runs on the PLL.
- `ST_FALLBACK`: the system runs on the oscillator after a PLL output failure.

The machine moves between these states as follows:
- `ST_BYP_RUN`→`ST_BYP_OFF` on an off request.
- `ST_BYP_RUN`→`ST_NORMAL` on a normal request with lock present.
- `ST_BYP_RUN`→`ST_WAIT_LOCK` on a normal request without lock.
- `ST_BYP_OFF`→`ST_BYP_RUN` on a run request.
- `ST_BYP_OFF`→`ST_WAIT_LOCK` on a normal request.
- `ST_WAIT_LOCK`→`ST_NORMAL` once lock is present.
- `ST_NORMAL`→`ST_WAIT_LOCK` when lock is lost.
- `ST_WAIT_LOCK` or `ST_NORMAL` back to either bypass state when the request changes.
- `ST_WAIT_LOCK` or `ST_NORMAL`→`ST_FALLBACK` on a PLL failure set to the interrupt response.
- `ST_FALLBACK`→`ST_BYP_OFF`, `ST_BYP_RUN` or `ST_WAIT_LOCK`, following the request, once the PLL fault flag reads zero.

In `ST_NORMAL`, a fallback takes priority over a request change, and a request change takes priority over loss of lock.

Top module: `clk_quality_supervisor`

## Requirements
- R1: After reset the block is in bypass with the PLL running: `pll_enable`=1, `clk_sel_pll`=0, `fault_flags`=0, `irq_req`=0 and `sys_rst_req`=0.
- R2: `mode_req` encodes 2'b00 = bypass with PLL off (`pll_enable`=0), 2'b01 or 2'b11 = bypass with PLL running, and 2'b10 = normal PLL mode. In both bypass modes `clk_sel_pll`=0.
- R3: `clk_sel_pll` goes to 1 only while the synchronized lock is present. A normal request made without lock is held pending and takes effect once lock arrives.
- R4: A monitored clock is in range when its rising-edge count over one window of `WIN` trusted cycles satisfies lo ≤ count ≤ hi, with both limits inclusive. Two out-of-range windows in a row declare a failure.
- R5: An oscillator failure sets flag bit 0. It raises `irq_req` when `fault_rst_sel[0]`=0 and pulses `sys_rst_req` when it is 1.
- R6: A PLL output failure sets flag bit 1. With `fault_rst_sel[1]`=1 it pulses `sys_rst_req` and the clock selection is unchanged. With `fault_rst_sel[1]`=0 it raises `irq_req` and drops `clk_sel_pll` to the oscillator.
- R7: After a fallback, `clk_sel_pll` stays 0 while flag bit 1 is set, even when the PLL output is healthy again. Once the flag is cleared, normal mode resumes under lock.
- R8: A falling edge of lock while the PLL is enabled sets flag bit 2. It raises `irq_req` when `fault_rst_sel[2]`=0 and pulses `sys_rst_req` when it is 1. Lock changes while the PLL is off have no effect.
- R9: `lock_ind` reports the lock input after a two-stage synchronizer.
- R10: Each flag stays set until a 1 is written to its bit of `fault_clr`. Clearing one bit leaves the other bits unchanged.
- R11: Each failure event set to the reset response produces exactly one `sys_rst_req` pulse, one trusted cycle long.
- R12: `irq_req` is high exactly when some set flag has its `fault_rst_sel` bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trusted supervision clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk_in | input | 1 | Oscillator clock, sampled as data |
| pll_clk_in | input | 1 | PLL output clock, sampled as data |
| pll_lock_in | input | 1 | Raw PLL lock flag |
| mode_req | input | 2 | Requested operating mode |
| osc_lim_lo | input | CW | Minimum oscillator edges per window |
| osc_lim_hi | input | CW | Maximum oscillator edges per window |
| pll_lim_lo | input | CW | Minimum PLL edges per window |
| pll_lim_hi | input | CW | Maximum PLL edges per window |
| fault_rst_sel | input | 3 | Per fault: 1 = reset response, 0 = interrupt response |
| fault_clr | input | 3 | Write-one-to-clear strobes for the flags |
| fault_flags | output | 3 | Sticky flags: bit0 oscillator, bit1 PLL, bit2 loss of lock |
| irq_req | output | 1 | Interrupt request |
| sys_rst_req | output | 1 | One-cycle system reset request |
| pll_enable | output | 1 | PLL power enable |
| clk_sel_pll | output | 1 | Clock mux select: 1 = PLL, 0 = oscillator |
| lock_ind | output | 1 | Synchronized lock indication |

## Verification
The bench drives the limits exactly onto the measured count (lo = hi = 8). A design that treats either limit as exclusive would flag a healthy PLL there, and one that ignores the upper bound would miss a PLL running at four times its rate. It parks a normal request while lock is absent and then removes both clocks together. This catches a selector that switches before lock, and a fallback that releases as soon as the clock recovers or as soon as the unrelated oscillator flag is cleared. It counts reset pulses per event, which exposes a failure that fires on every bad window or a pulse that is too long. It also drops lock while the PLL is off, which a design that does not gate that path would report as a fault.

// File: rtl/ckmon_pkg.sv
package ckmon_pkg;

    typedef enum logic [2:0] {
        ST_BYP_OFF,
        ST_BYP_RUN,
        ST_WAIT_LOCK,
        ST_NORMAL,
        ST_FALLBACK
    } mode_st_t;

    typedef enum logic [1:0] {
        HL_GOOD,
        HL_SUSPECT,
        HL_FAILED
    } health_t;

    localparam logic [1:0] REQ_OFF  = 2'b00;
    localparam logic [1:0] REQ_RUN  = 2'b01;
    localparam logic [1:0] REQ_NORM = 2'b10;

    localparam int FLT_OSC = 0;
    localparam int FLT_PLL = 1;
    localparam int FLT_LOL = 2;
    localparam int NUM_FLT = 3;
    localparam int NUM_MON = 2;

endpackage

// File: rtl/ckmon_rate_mon.sv
module ckmon_rate_mon
    import ckmon_pkg::*;
#(
    parameter int CW   = 8,
    parameter int WIN  = 64,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          mon_in,
    input  logic [CW-1:0] lim_lo,
    input  logic [CW-1:0] lim_hi,
    output logic          fail_evt
);

    localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;

    logic [SYNC:0]  sh_q;
    logic [WW-1:0]  win_q;
    logic [CW-1:0]  edge_q;
    logic [CW-1:0]  total;
    health_t        hl_q, hl_d;
    logic           rise, win_end, in_rng;

    assign rise    = sh_q[SYNC-1] & ~sh_q[SYNC];
    assign win_end = (win_q == WW'(WIN - 1));

    always_comb begin
        total = edge_q;
        if (rise && (edge_q != '1)) begin
            total = edge_q + CW'(1);
        end
    end

    assign in_rng = (total >= lim_lo) && (total <= lim_hi);

    // health state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            win_q  <= '0;
            edge_q <= '0;
            hl_q   <= HL_GOOD;
        end else if (!en) begin
            sh_q   <= '0;
            win_q  <= '0;
            edge_q <= '0;
            hl_q   <= HL_GOOD;
        end else begin
            sh_q   <= {sh_q[SYNC-1:0], mon_in};
            win_q  <= win_end ? '0 : win_q + WW'(1);
            edge_q <= win_end ? '0 : total;
            hl_q   <= hl_d;
        end
    end

    // health next state
    always_comb begin
        hl_d = hl_q;
        unique case (hl_q)
            HL_GOOD: begin
                if (win_end && !in_rng) hl_d = HL_SUSPECT;
            end
            HL_SUSPECT: begin
                if (win_end) hl_d = in_rng ? HL_GOOD : HL_FAILED;
            end
            HL_FAILED: begin
                if (win_end && in_rng) hl_d = HL_GOOD;
            end
            default: hl_d = HL_GOOD;
        endcase
    end

    // failure event output
    always_comb begin
        fail_evt = en && win_end && !in_rng && (hl_q == HL_SUSPECT);
    end

    // R4: a failure is a single-cycle event at a window boundary
    assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fail_evt |=> !fail_evt);

    // R4: a failed verdict only changes at a window boundary
    assert_failed_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hl_q == HL_FAILED && en && !win_end) |=> (hl_q == HL_FAILED));

endmodule

// File: rtl/ckmon_fault_resp.sv
module ckmon_fault_resp
    import ckmon_pkg::*;
#(
    parameter int NF = NUM_FLT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] ev,
    input  logic [NF-1:0] rst_sel,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] flags,
    output logic          irq_req,
    output logic          sys_rst_req,
    output logic          fallback_evt
);

    logic [NF-1:0] flags_q;
    logic          rst_q;

    generate
        for (genvar i = 0; i < NF; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags_q[i] <= 1'b0;
                end else if (ev[i]) begin
                    flags_q[i] <= 1'b1;
                end else if (clr[i]) begin
                    flags_q[i] <= 1'b0;
                end
            end

            // R10: a set flag survives every cycle without its clear strobe
            assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_q[i] && !clr[i]) |=> flags_q[i]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q <= 1'b0;
        end else begin
            rst_q <= |(ev & rst_sel);
        end
    end

    always_comb begin
        flags        = flags_q;
        sys_rst_req  = rst_q;
        irq_req      = |(flags_q & ~rst_sel);
        fallback_evt = ev[FLT_PLL] & ~rst_sel[FLT_PLL];
    end

    // R11: a reset request is always caused by a reset-routed event
    assert_rst_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(|(ev & rst_sel)));

    // R12: an interrupt needs a raised flag
    assert_irq_needs_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (flags_q != '0));

endmodule

// File: rtl/ckmon_mode_fsm.sv
module ckmon_mode_fsm
    import ckmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_req,
    input  logic       lock_ok,
    input  logic       fallback_evt,
    input  logic       pll_flag,
    output logic       pll_enable,
    output logic       clk_sel_pll
);

    mode_st_t st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_BYP_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BYP_OFF: begin
                if (mode_req == REQ_NORM)     st_d = ST_WAIT_LOCK;
                else if (mode_req != REQ_OFF) st_d = ST_BYP_RUN;
            end
            ST_BYP_RUN: begin
                if (mode_req == REQ_OFF)       st_d = ST_BYP_OFF;
                else if (mode_req == REQ_NORM) st_d = lock_ok ? ST_NORMAL : ST_WAIT_LOCK;
            end
            ST_WAIT_LOCK: begin
                if (fallback_evt)              st_d = ST_FALLBACK;
                else if (mode_req == REQ_OFF)  st_d = ST_BYP_OFF;
                else if (mode_req != REQ_NORM) st_d = ST_BYP_RUN;
                else if (lock_ok)              st_d = ST_NORMAL;
            end
            ST_NORMAL: begin
                if (fallback_evt)              st_d = ST_FALLBACK;
                else if (mode_req == REQ_OFF)  st_d = ST_BYP_OFF;
                else if (mode_req != REQ_NORM) st_d = ST_BYP_RUN;
                else if (!lock_ok)             st_d = ST_WAIT_LOCK;
            end
            ST_FALLBACK: begin
                if (!pll_flag) begin
                    if (mode_req == REQ_OFF)       st_d = ST_BYP_OFF;
                    else if (mode_req == REQ_NORM) st_d = ST_WAIT_LOCK;
                    else                           st_d = ST_BYP_RUN;
                end
            end
            default: st_d = ST_BYP_RUN;
        endcase
    end

    // outputs
    always_comb begin
        pll_enable  = 1'b1;
        clk_sel_pll = 1'b0;
        unique case (st_q)
            ST_BYP_OFF:   pll_enable = 1'b0;
            ST_BYP_RUN:   ;
            ST_WAIT_LOCK: ;
            ST_NORMAL:    clk_sel_pll = 1'b1;
            ST_FALLBACK:  ;
            default:      pll_enable = 1'b1;
        endcase
    end

    // R3: PLL selection is only ever held with lock present on the previous edge
    assert_sel_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_NORMAL) |-> $past(lock_ok));

    // R7: fallback is kept while the PLL fault flag is set
    assert_fallback_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FALLBACK && pll_flag) |=> (st_q == ST_FALLBACK));

    // R2: the PLL is powered down only on an off request
    assert_off_by_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BYP_OFF) |-> ($past(mode_req) == REQ_OFF));

endmodule

// File: rtl/clk_quality_supervisor.sv
module clk_quality_supervisor
    import ckmon_pkg::*;
#(
    parameter int CW   = 8,
    parameter int WIN  = 64,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          osc_clk_in,
    input  logic          pll_clk_in,
    input  logic          pll_lock_in,
    input  logic [1:0]    mode_req,
    input  logic [CW-1:0] osc_lim_lo,
    input  logic [CW-1:0] osc_lim_hi,
    input  logic [CW-1:0] pll_lim_lo,
    input  logic [CW-1:0] pll_lim_hi,
    input  logic [2:0]    fault_rst_sel,
    input  logic [2:0]    fault_clr,
    output logic [2:0]    fault_flags,
    output logic          irq_req,
    output logic          sys_rst_req,
    output logic          pll_enable,
    output logic          clk_sel_pll,
    output logic          lock_ind
);

    logic [NUM_MON-1:0] mon_in, mon_en, mon_fail;
    logic [CW-1:0]      mon_lo [NUM_MON];
    logic [CW-1:0]      mon_hi [NUM_MON];
    logic [SYNC:0]      lk_q;
    logic               lock_s, lol_ev, fallback_evt;
    logic [NUM_FLT-1:0] ev;

    assign mon_in[FLT_OSC] = osc_clk_in;
    assign mon_in[FLT_PLL] = pll_clk_in;
    assign mon_en[FLT_OSC] = 1'b1;
    assign mon_en[FLT_PLL] = pll_enable;
    assign mon_lo[FLT_OSC] = osc_lim_lo;
    assign mon_hi[FLT_OSC] = osc_lim_hi;
    assign mon_lo[FLT_PLL] = pll_lim_lo;
    assign mon_hi[FLT_PLL] = pll_lim_hi;

    generate
        for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
            ckmon_rate_mon #(
                .CW   (CW),
                .WIN  (WIN),
                .SYNC (SYNC)
            ) u_mon (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (mon_en[m]),
                .mon_in   (mon_in[m]),
                .lim_lo   (mon_lo[m]),
                .lim_hi   (mon_hi[m]),
                .fail_evt (mon_fail[m])
            );
        end
    endgenerate

    // lock synchronizer plus one history stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= {lk_q[SYNC-1:0], pll_lock_in};
        end
    end

    assign lock_s   = lk_q[SYNC-1];
    assign lock_ind = lock_s;
    assign lol_ev   = pll_enable & lk_q[SYNC] & ~lk_q[SYNC-1];

    assign ev[FLT_OSC] = mon_fail[FLT_OSC];
    assign ev[FLT_PLL] = mon_fail[FLT_PLL];
    assign ev[FLT_LOL] = lol_ev;

    ckmon_fault_resp #(
        .NF (NUM_FLT)
    ) u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           (ev),
        .rst_sel      (fault_rst_sel),
        .clr          (fault_clr),
        .flags        (fault_flags),
        .irq_req      (irq_req),
        .sys_rst_req  (sys_rst_req),
        .fallback_evt (fallback_evt)
    );

    ckmon_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_req     (mode_req),
        .lock_ok      (lock_s),
        .fallback_evt (fallback_evt),
        .pll_flag     (fault_flags[FLT_PLL]),
        .pll_enable   (pll_enable),
        .clk_sel_pll  (clk_sel_pll)
    );

    // R8: lock loss while the PLL is off never raises the lock flag
    assert_lol_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_enable && !fault_flags[FLT_LOL]) |=> !fault_flags[FLT_LOL]);

    // R9: the lock indication follows the raw input through the synchronizer
    assert_lock_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_ind) |-> $past(pll_lock_in, 2));

endmodule

// File: tb/clk_quality_supervisor_test.sv
module clk_quality_supervisor_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CW  = 8;
    localparam int WIN = 64;

    typedef struct packed {
        logic [3:0] osc_half;
        logic [3:0] pll_half;
        logic       lock;
        logic [2:0] rsel;
        logic [2:0] ex_flags;
        logic [1:0] ex_rst;
        logic       ex_irq;
        logic       ex_sel;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{4'd4, 4'd4, 1'b1, 3'b000, 3'b000, 2'd0, 1'b0, 1'b1},  // healthy, R4
        '{4'd0, 4'd4, 1'b1, 3'b000, 3'b001, 2'd0, 1'b1, 1'b1},  // osc stopped, irq, R5
        '{4'd0, 4'd4, 1'b1, 3'b001, 3'b001, 2'd1, 1'b0, 1'b1},  // osc stopped, reset, R5
        '{4'd4, 4'd0, 1'b1, 3'b000, 3'b010, 2'd0, 1'b1, 1'b0},  // pll stopped, fallback, R6
        '{4'd4, 4'd0, 1'b1, 3'b010, 3'b010, 2'd1, 1'b0, 1'b1},  // pll stopped, reset, R6
        '{4'd4, 4'd1, 1'b1, 3'b000, 3'b010, 2'd0, 1'b1, 1'b0},  // pll too fast, R4 R6
        '{4'd4, 4'd4, 1'b0, 3'b000, 3'b100, 2'd0, 1'b1, 1'b0},  // lock lost, irq, R8
        '{4'd4, 4'd4, 1'b0, 3'b100, 3'b100, 2'd1, 1'b0, 1'b0},  // lock lost, reset, R8
        '{4'd8, 4'd4, 1'b1, 3'b000, 3'b001, 2'd0, 1'b1, 1'b1}   // osc too slow, R4 R5
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_in = 1'b0;
    logic          pll_in = 1'b0;
    logic          lock = 1'b0;
    logic [1:0]    mode_req = 2'b01;
    logic [CW-1:0] osc_lo = 8'd6, osc_hi = 8'd10, pll_lo = 8'd6, pll_hi = 8'd10;
    logic [2:0]    rsel = 3'b000;
    logic [2:0]    clr = 3'b000;
    logic [2:0]    flags;
    logic          irq, sysrst, pll_en, sel_pll, lock_ind;

    logic [3:0]    osc_half = 4'd4;
    logic [3:0]    pll_half = 4'd4;
    int            ocnt = 0;
    int            pcnt = 0;
    int            rst_seen = 0;
    int            total = 0;
    int            bad = 0;
    bit            wd_hit = 1'b0;

    always #2.5 clk = ~clk;

    clk_quality_supervisor #(.CW(CW), .WIN(WIN), .SYNC(2)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .osc_clk_in    (osc_in),
        .pll_clk_in    (pll_in),
        .pll_lock_in   (lock),
        .mode_req      (mode_req),
        .osc_lim_lo    (osc_lo),
        .osc_lim_hi    (osc_hi),
        .pll_lim_lo    (pll_lo),
        .pll_lim_hi    (pll_hi),
        .fault_rst_sel (rsel),
        .fault_clr     (clr),
        .fault_flags   (flags),
        .irq_req       (irq),
        .sys_rst_req   (sysrst),
        .pll_enable    (pll_en),
        .clk_sel_pll   (sel_pll),
        .lock_ind      (lock_ind)
    );

    always @(negedge clk) begin
        if (osc_half == 4'd0) ocnt <= 0;
        else if (ocnt + 1 >= int'(osc_half)) begin ocnt <= 0; osc_in <= ~osc_in; end
        else ocnt <= ocnt + 1;
    end

    always @(negedge clk) begin
        if (pll_half == 4'd0) pcnt <= 0;
        else if (pcnt + 1 >= int'(pll_half)) begin pcnt <= 0; pll_in <= ~pll_in; end
        else pcnt <= pcnt + 1;
    end

    always @(posedge clk) begin
        if (rst_n && sysrst) rst_seen <= rst_seen + 1;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic restore();
        osc_half = 4'd4; pll_half = 4'd4; lock = 1'b1; rsel = 3'b000;
        step(3 * WIN);
        clr = 3'b111;
        step(1);
        clr = 3'b000;
        step(8);
    endtask

    task automatic run_all();
        int base;
        step(3);
        rst_n = 1'b1;
        step(2);
        // R1 reset state
        chk("R1 pll_enable", int'(pll_en), 1);
        chk("R1 clk_sel_pll", int'(sel_pll), 0);
        chk("R1 flags", int'(flags), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 sys_rst_req", int'(sysrst), 0);

        // R3 normal request without lock is held pending
        mode_req = 2'b10;
        step(20);
        chk("R3 pending sel", int'(sel_pll), 0);
        chk("R3 pending pll_enable", int'(pll_en), 1);
        chk("R9 lock_ind low", int'(lock_ind), 0);
        lock = 1'b1;
        step(10);
        chk("R9 lock_ind high", int'(lock_ind), 1);
        chk("R3 sel after lock", int'(sel_pll), 1);
        step(2 * WIN);

        // vector table
        for (int i = 0; i < NV; i++) begin
            base = rst_seen;
            osc_half = VEC[i].osc_half;
            pll_half = VEC[i].pll_half;
            lock     = VEC[i].lock;
            rsel     = VEC[i].rsel;
            step(6 * WIN);
            chk($sformatf("R10 vec%0d flags", i), int'(flags), int'(VEC[i].ex_flags));
            chk($sformatf("R12 vec%0d irq", i), int'(irq), int'(VEC[i].ex_irq));
            chk($sformatf("R11 vec%0d reset pulses", i), rst_seen - base, int'(VEC[i].ex_rst));
            chk($sformatf("R6 vec%0d clk_sel_pll", i), int'(sel_pll), int'(VEC[i].ex_sel));
            restore();
            chk($sformatf("R10 vec%0d cleared", i), int'(flags), 0);
        end

        // R7 / R10: fallback stays until the PLL flag itself is cleared
        osc_half = 4'd0; pll_half = 4'd0;
        step(6 * WIN);
        chk("R5 R6 both flags", int'(flags), 3);
        chk("R7 fallback sel", int'(sel_pll), 0);
        osc_half = 4'd4; pll_half = 4'd4;
        step(4 * WIN);
        chk("R7 sel held after recovery", int'(sel_pll), 0);
        clr = 3'b001; step(1); clr = 3'b000;
        step(4);
        chk("R10 clear one bit", int'(flags), 2);
        chk("R7 sel held with pll flag", int'(sel_pll), 0);
        clr = 3'b010; step(1); clr = 3'b000;
        step(6);
        chk("R10 pll flag cleared", int'(flags), 0);
        chk("R7 resume normal", int'(sel_pll), 1);

        // R4 inclusive limits
        pll_lo = 8'd8; pll_hi = 8'd8;
        step(6 * WIN);
        chk("R4 count on limits", int'(flags), 0);
        pll_hi = 8'd7;
        step(4 * WIN);
        chk("R4 count above max", int'(flags), 2);
        pll_lo = 8'd6; pll_hi = 8'd10;
        restore();
        step(4);
        chk("R7 normal after clear", int'(sel_pll), 1);

        // R2 / R8: power down and lock changes while off
        mode_req = 2'b00;
        step(3);
        chk("R2 off pll_enable", int'(pll_en), 0);
        chk("R2 off sel", int'(sel_pll), 0);
        lock = 1'b0;
        step(2 * WIN);
        chk("R8 lock drop while off flags", int'(flags), 0);
        chk("R8 lock drop while off irq", int'(irq), 0);
        mode_req = 2'b11;
        step(3);
        chk("R2 code 11 pll_enable", int'(pll_en), 1);
        chk("R2 code 11 sel", int'(sel_pll), 0);
        lock = 1'b1;
        mode_req = 2'b01;
        step(10);
        chk("R2 bypass run sel", int'(sel_pll), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        if (wd_hit) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule